// File: doc/BRIEF.md
# Pending-Interrupt Bitmap Set/Clear Controller

This block keeps the pending state of message-signalled interrupts as a bitmap, one bit per interrupt ID, held in a small on-chip byte array. Software writes an ID to a set register or a clear register to change one bit. A CPU acknowledge port can also clear a bit once the interrupt is taken. An acknowledged interrupt gets no active state. Its pending bit is simply dropped.

Each change that is accepted runs as a byte read, a one-bit modify and a byte write-back. After the write-back the block raises a single-cycle change pulse, so that a downstream priority selector knows to rescan. That selector reads single bits through a combinational lookup port. Requests are dropped without effect in three cases: the global enable is off, the ID is beyond the configured limit, or the bit already holds the requested value.

Top module: `lpi_pend_ctrl`

## Requirements
- R1: After reset the enable reads 0, the ID-width field reads 0, every bitmap bit is 0, both ready outputs are 1 and the change pulse is 0.
- R2: When enabled, a write to offset 0x40 carrying ID `n` in data bits [31:0] sets bit `n%8` of byte `n/8`. The other bits of that byte are left as they were. The ready outputs stay low for exactly three cycles after the accepting edge.
- R3: When enabled, a write to offset 0x48 carrying ID `n` clears that bit, with the same three-cycle busy window.
- R4: While the enable (bit 0 of the control register at offset 0x00) is 0, set, clear and acknowledge requests change no bit, raise no pulse and leave the block ready.
- R5: The ID-width field (bits [4:0] at offset 0x70) is clamped to MAX_IDBITS on write. A request whose ID is larger than 2^(field+1) is ignored. An ID equal to that limit is accepted.
- R6: A set to an ID that is already pending, or a clear to an ID that is not pending, leaves the bitmap as it was and raises no pulse.
- R7: An acknowledge of an ID at or above LPI_BASE (8192) clears its bit in the same way as a clear write. An acknowledge of a lower ID is ignored.
- R8: The change pulse is high for exactly one cycle, in the cycle after the byte write-back, and only for requests that changed a bit.
- R9: The control register reads back the enable in bit 0 and three stored control bits in bits 26:24, with all other bits 0. The synchronize register at offset 0xC0 reads 0.
- R10: At most one request is granted per cycle. When a write and an acknowledge are presented together the acknowledge wins, and the write waits until the block is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | DATA_W | Combinational register read data |
| ack_valid | input | 1 | CPU acknowledge request |
| ack_ready | output | 1 | Acknowledge accepted when high together with ack_valid |
| ack_id | input | ID_W | Acknowledged interrupt ID |
| scan_id | input | ID_W | ID looked up by the priority selector |
| scan_pending | output | 1 | Pending bit for scan_id |
| change_pulse | output | 1 | One-cycle pulse after an accepted bitmap change |

## Verification
The bench builds the block with its defaults: MAX_IDBITS of 13, LPI_BASE of 8192 and the acknowledge-first arbitration variant. This gives a bitmap of 2049 bytes, so the inclusive limit ID 16384 and the first ID past it, 16385, both fall inside the array and both edges of the range check can be reached. The bench also narrows the ID-width field to 3 to test a small limit. It writes 31 to that field to test the clamp. Random traffic is concentrated on eight bytes just above 8192 so that repeated sets and clears hit the no-change path often.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_MODIFY,
      ST_WRITE
   } rmw_state_t;

   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_SET  = 8'h40;
   localparam logic [7:0] OFF_CLR  = 8'h48;
   localparam logic [7:0] OFF_CFG  = 8'h70;
   localparam logic [7:0] OFF_SYNC = 8'hC0;

   localparam int CTRL_HI_LSB = 24;
   localparam int CTRL_HI_W   = 3;
   localparam int CFG_W       = 5;

endpackage

// File: rtl/lpi_pend_regs.sv
module lpi_pend_regs
   import lpi_pend_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int ID_W       = 32,
   parameter int MAX_IDBITS = 13,
   parameter int LPI_BASE   = 8192,
   parameter bit ACK_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ack_valid,
   output logic              ack_ready,
   input  logic [ID_W-1:0]   ack_id,
   input  logic              busy,
   output logic              cmd_go,
   output logic              cmd_set,
   output logic [ID_W-1:0]   cmd_id,
   output logic              lpi_en,
   output logic [CFG_W-1:0]  idbits
);

   localparam logic [CFG_W-1:0] CFG_MAX = CFG_W'(MAX_IDBITS);

   logic                 en_q;
   logic [CTRL_HI_W-1:0] hi_q;
   logic [CFG_W-1:0]     idbits_q;
   logic [ID_W:0]        id_limit;
   logic                 wr_take, ack_take;
   logic                 hit_set, hit_clr;
   logic [ID_W-1:0]      wr_id;
   logic                 wr_in_range, ack_in_range, ack_is_lpi;
   logic                 set_go, clr_go, ack_go;
   logic [CFG_W-1:0]     cfg_in;

   // arbitration variant
   generate
      if (ACK_FIRST) begin : g_ack_first
         assign ack_ready = !busy;
         assign wr_ready  = !busy && !ack_valid;
      end else begin : g_wr_first
         assign wr_ready  = !busy;
         assign ack_ready = !busy && !wr_valid;
      end
   endgenerate

   assign wr_take  = wr_valid && wr_ready;
   assign ack_take = ack_valid && ack_ready;
   assign hit_set  = (wr_addr == ADDR_W'(OFF_SET));
   assign hit_clr  = (wr_addr == ADDR_W'(OFF_CLR));
   assign wr_id    = wr_data[ID_W-1:0];

   assign id_limit     = {{ID_W{1'b0}}, 1'b1} << (idbits_q + CFG_W'(1));
   assign wr_in_range  = ({1'b0, wr_id} <= id_limit);
   assign ack_in_range = ({1'b0, ack_id} <= id_limit);
   assign ack_is_lpi   = (ack_id >= ID_W'(LPI_BASE));

   assign set_go = wr_take && hit_set && en_q && wr_in_range;
   assign clr_go = wr_take && hit_clr && en_q && wr_in_range;
   assign ack_go = ack_take && en_q && ack_is_lpi && ack_in_range;

   assign cmd_go  = set_go || clr_go || ack_go;
   assign cmd_set = set_go;
   assign cmd_id  = ack_go ? ack_id : wr_id;

   assign cfg_in = wr_data[CFG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         hi_q     <= '0;
         idbits_q <= '0;
      end else if (wr_take) begin
         if (wr_addr == ADDR_W'(OFF_CTRL)) begin
            en_q <= wr_data[0];
            hi_q <= wr_data[CTRL_HI_LSB +: CTRL_HI_W];
         end else if (wr_addr == ADDR_W'(OFF_CFG)) begin
            idbits_q <= (cfg_in > CFG_MAX) ? CFG_MAX : cfg_in;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(OFF_CTRL)) begin
         rd_data[0]                         = en_q;
         rd_data[CTRL_HI_LSB +: CTRL_HI_W]  = hi_q;
      end else if (rd_addr == ADDR_W'(OFF_CFG)) begin
         rd_data[CFG_W-1:0] = idbits_q;
      end else if (rd_addr == ADDR_W'(OFF_SYNC)) begin
         rd_data = '0;
      end
   end

   assign lpi_en = en_q;
   assign idbits = idbits_q;

endmodule

// File: rtl/lpi_pend_rmw.sv
module lpi_pend_rmw
   import lpi_pend_pkg::*;
#(
   parameter int ID_W  = 32,
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_go,
   input  logic             cmd_set,
   input  logic [ID_W-1:0]  cmd_id,
   input  logic [7:0]       mem_rd_byte,
   output logic             busy,
   output logic [IDX_W-1:0] mem_idx,
   output logic             mem_wr_en,
   output logic [7:0]       mem_wr_byte,
   output logic             change
);

   rmw_state_t       st_q;
   logic [IDX_W-1:0] idx_q;
   logic [2:0]       bit_q;
   logic             set_q;
   logic [7:0]       byte_q;
   logic             upd_q;
   logic             chg_q;
   logic [7:0]       mask;
   logic             cur;

   assign mask = 8'b1 << bit_q;
   assign cur  = |(byte_q & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         bit_q  <= '0;
         set_q  <= 1'b0;
         byte_q <= '0;
         upd_q  <= 1'b0;
         chg_q  <= 1'b0;
      end else begin
         chg_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (cmd_go) begin
                  idx_q <= IDX_W'(cmd_id >> 3);
                  bit_q <= cmd_id[2:0];
                  set_q <= cmd_set;
                  st_q  <= ST_READ;
               end
            end
            ST_READ: begin
               byte_q <= mem_rd_byte;
               st_q   <= ST_MODIFY;
            end
            ST_MODIFY: begin
               upd_q  <= set_q ? !cur : cur;
               byte_q <= set_q ? (byte_q | mask) : (byte_q & ~mask);
               st_q   <= ST_WRITE;
            end
            ST_WRITE: begin
               chg_q <= upd_q;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (st_q != ST_IDLE);
   assign mem_idx     = idx_q;
   assign mem_wr_en   = (st_q == ST_WRITE) && upd_q;
   assign mem_wr_byte = byte_q;
   assign change      = chg_q;

endmodule

// File: rtl/lpi_pend_mem.sv
module lpi_pend_mem #(
   parameter int ID_W  = 32,
   parameter int DEPTH = 2049,
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       rd_byte,
   input  logic             wr_en,
   input  logic [7:0]       wr_byte,
   input  logic [ID_W-1:0]  scan_id,
   output logic             scan_bit
);

   logic [7:0]      mem_q [DEPTH];
   logic [ID_W-1:0] scan_idx;
   logic [7:0]      scan_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
      end else if (wr_en && (32'(idx) < DEPTH)) begin
         mem_q[idx] <= wr_byte;
      end
   end

   assign rd_byte   = (32'(idx) < DEPTH) ? mem_q[idx] : 8'h00;
   assign scan_idx  = scan_id >> 3;
   assign scan_byte = (scan_idx < ID_W'(DEPTH)) ? mem_q[IDX_W'(scan_idx)] : 8'h00;
   assign scan_bit  = scan_byte[scan_id[2:0]];

endmodule

// File: rtl/lpi_pend_ctrl.sv
module lpi_pend_ctrl
   import lpi_pend_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int ID_W       = 32,
   parameter int MAX_IDBITS = 13,
   parameter int LPI_BASE   = 8192,
   parameter bit ACK_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ack_valid,
   output logic              ack_ready,
   input  logic [ID_W-1:0]   ack_id,
   input  logic [ID_W-1:0]   scan_id,
   output logic              scan_pending,
   output logic              change_pulse
);

   localparam int LIMIT_MAX = 1 << (MAX_IDBITS + 1);
   localparam int MEM_BYTES = LIMIT_MAX / 8 + 1;
   localparam int IDX_W     = $clog2(MEM_BYTES);

   initial begin
      assert (ADDR_W >= 8) else $error("ADDR_W must cover offset 0xC0");
      assert (DATA_W >= 27) else $error("DATA_W must hold control bits 26:24");
      assert (ID_W <= DATA_W) else $error("ID_W exceeds DATA_W");
      assert (MAX_IDBITS >= 3 && MAX_IDBITS <= 15) else $error("MAX_IDBITS out of range");
      assert (MAX_IDBITS + 2 <= ID_W) else $error("ID_W too narrow for the limit");
      assert (LPI_BASE > 0 && LPI_BASE <= LIMIT_MAX) else $error("LPI_BASE out of range");
   end

   logic                 busy;
   logic                 cmd_go, cmd_set;
   logic [ID_W-1:0]      cmd_id;
   logic                 lpi_en;
   logic [CFG_W-1:0]     idbits;
   logic [IDX_W-1:0]     mem_idx;
   logic [7:0]           mem_rd_byte, mem_wr_byte;
   logic                 mem_wr_en;

   lpi_pend_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .MAX_IDBITS(MAX_IDBITS), .LPI_BASE(LPI_BASE), .ACK_FIRST(ACK_FIRST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_id(ack_id),
      .busy(busy), .cmd_go(cmd_go), .cmd_set(cmd_set), .cmd_id(cmd_id),
      .lpi_en(lpi_en), .idbits(idbits)
   );

   lpi_pend_rmw #(.ID_W(ID_W), .IDX_W(IDX_W)) u_rmw (
      .clk(clk), .rst_n(rst_n),
      .cmd_go(cmd_go), .cmd_set(cmd_set), .cmd_id(cmd_id),
      .mem_rd_byte(mem_rd_byte), .busy(busy), .mem_idx(mem_idx),
      .mem_wr_en(mem_wr_en), .mem_wr_byte(mem_wr_byte), .change(change_pulse)
   );

   lpi_pend_mem #(.ID_W(ID_W), .DEPTH(MEM_BYTES), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .idx(mem_idx), .rd_byte(mem_rd_byte),
      .wr_en(mem_wr_en), .wr_byte(mem_wr_byte),
      .scan_id(scan_id), .scan_bit(scan_pending)
   );

endmodule

// File: rtl/lpi_pend_ctrl_chk.sv
module lpi_pend_ctrl_chk
   import lpi_pend_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int ID_W     = 32,
   parameter int LPI_BASE = 8192
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              ack_valid,
   input logic              ack_ready,
   input logic [ID_W-1:0]   ack_id,
   input logic              change_pulse,
   input logic              lpi_en,
   input logic [CFG_W-1:0]  idbits
);

   logic          take, wr_take, ack_take, idle_next;
   logic [ID_W:0] lim;
   logic          wr_is_cmd;

   assign wr_take   = wr_valid && wr_ready;
   assign ack_take  = ack_valid && ack_ready;
   assign take      = wr_take || ack_take;
   assign idle_next = ack_ready || wr_ready;
   assign lim       = (ID_W+1)'(1) << (32'(idbits) + 1);
   assign wr_is_cmd = (wr_addr == ADDR_W'(OFF_SET)) || (wr_addr == ADDR_W'(OFF_CLR));

   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !change_pulse);

   p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      change_pulse |=> !change_pulse);

   p_pulse_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      change_pulse |-> idle_next && $past(!ack_ready && !wr_ready));

   p_disabled_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !lpi_en) |=> idle_next);

   p_range_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_take && wr_is_cmd && ({1'b0, wr_data[ID_W-1:0]} > lim)) |=> idle_next);

   p_ack_low_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && (ack_id < ID_W'(LPI_BASE))) |=> idle_next);

   p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_take && ack_take));

   p_sync_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(OFF_SYNC)) |-> (rd_data == '0));

endmodule

bind lpi_pend_ctrl lpi_pend_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LPI_BASE(LPI_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_addr(rd_addr), .rd_data(rd_data),
   .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_id(ack_id),
   .change_pulse(change_pulse), .lpi_en(lpi_en), .idbits(idbits)
);

// File: tb/lpi_pend_ctrl_tb.sv
module lpi_pend_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MODEL_BITS = 16392;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        ack_valid = 1'b0;
   logic        ack_ready;
   logic [31:0] ack_id = '0;
   logic [31:0] scan_id = '0;
   logic        scan_pending;
   logic        change_pulse;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   bit mdl [MODEL_BITS];
   bit en_m = 1'b0;
   int idb_m = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpi_pend_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_id(ack_id),
      .scan_id(scan_id), .scan_pending(scan_pending), .change_pulse(change_pulse)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit accepted(input int kind, input int id);
      longint lim = longint'(1) << (idb_m + 1);
      if (!en_m) return 1'b0;
      if (longint'(id) > lim) return 1'b0;
      if (kind == 2 && id < 8192) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit changes(input int kind, input int id);
      if (!accepted(kind, id)) return 1'b0;
      return (kind == 0) ? !mdl[id] : mdl[id];
   endfunction

   task automatic scan_check(input int id, input string req);
      scan_id = 32'(id);
      #1;
      check(scan_pending == ((id < MODEL_BITS) ? mdl[id] : 1'b0), req,
            scan_pending, (id < MODEL_BITS) ? mdl[id] : 0);
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, input logic [31:0] exp, input string req);
      rd_addr = a;
      #1;
      check(rd_data == exp, req, rd_data, exp);
   endtask

   // samples six falling edges starting at the first one after acceptance
   task automatic observe(input int exp_busy, input bit exp_pulse, input string req);
      int busy_n = 0;
      int pulse_n = 0;
      int pulse_at = 0;
      for (int k = 1; k <= 6; k++) begin
         if (k > 1) @(negedge clk);
         if (!ack_ready) busy_n++;
         if (change_pulse) begin pulse_n++; pulse_at = k; end
      end
      check(busy_n == exp_busy, {req, " busy"}, busy_n, exp_busy);
      check(pulse_n == int'(exp_pulse), {req, " pulse"}, pulse_n, exp_pulse);
      if (exp_pulse) check(pulse_at == 4, {req, " pulse cycle"}, pulse_at, 4);
   endtask

   // kind: 0 set, 1 clear, 2 acknowledge
   task automatic op(input int kind, input int id, input string req);
      bit acc = accepted(kind, id);
      bit chg = changes(kind, id);
      if (kind == 2) begin
         @(negedge clk);
         while (!ack_ready) @(negedge clk);
         ack_valid = 1'b1; ack_id = 32'(id);
         @(negedge clk);
         ack_valid = 1'b0;
      end else begin
         reg_write(kind == 0 ? 8'h40 : 8'h48, 32'(id));
      end
      observe(acc ? 3 : 0, chg, req);
      if (chg) mdl[id] = (kind == 0);
      scan_check(id, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < MODEL_BITS; i++) mdl[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
      check(ack_ready == 1'b1, "R1 ack_ready", ack_ready, 1);
      check(change_pulse == 1'b0, "R1 pulse", change_pulse, 0);
      reg_read(8'h00, 32'h0, "R1 ctrl");
      reg_read(8'h70, 32'h0, "R1 idbits");
      scan_check(8192, "R1 bitmap");
      scan_check(2, "R1 bitmap low");

      // R4 disabled: all requests ignored
      op(0, 2, "R4 set disabled");

      // R9 control readback and synchronize register
      reg_write(8'h00, 32'h0700_0001); en_m = 1'b1;
      reg_read(8'h00, 32'h0700_0001, "R9 ctrl");
      reg_write(8'h00, 32'hFFFF_FFFF);
      reg_read(8'h00, 32'h0700_0001, "R9 ctrl mask");
      reg_read(8'hC0, 32'h0, "R9 sync");

      // R5 clamp
      reg_write(8'h70, 32'h1F); idb_m = 13;
      reg_read(8'h70, 32'd13, "R5 clamp");

      // R2 set, neighbours untouched
      op(0, 8192, "R2 set");
      scan_check(8193, "R2 neighbour");
      op(0, 8195, "R2 set same byte");
      scan_check(8192, "R2 neighbour kept");

      // R6 no-change requests
      op(0, 8192, "R6 set pending");
      op(1, 8200, "R6 clear idle");

      // R3 clear
      op(1, 8195, "R3 clear");
      scan_check(8192, "R3 neighbour kept");

      // R5 limit edges
      op(0, 16384, "R5 at limit");
      op(0, 16385, "R5 above limit");

      // R7 acknowledge
      op(2, 8192, "R7 ack clears");
      op(0, 100, "R2 set low id");
      op(2, 100, "R7 ack low id ignored");
      scan_check(100, "R7 low id kept");

      // R5 narrow limit
      reg_write(8'h70, 32'd3); idb_m = 3;
      op(0, 17, "R5 narrow above");
      op(0, 16, "R5 narrow at");
      reg_write(8'h70, 32'd13); idb_m = 13;

      // R10 simultaneous requests
      op(0, 9000, "R10 setup");
      @(negedge clk);
      ack_valid = 1'b1; ack_id = 32'd9000;
      wr_valid = 1'b1; wr_addr = 8'h40; wr_data = 32'd9001;
      #1;
      check(wr_ready == 1'b0, "R10 write held", wr_ready, 0);
      check(ack_ready == 1'b1, "R10 ack granted", ack_ready, 1);
      @(negedge clk);
      ack_valid = 1'b0;
      check(wr_ready == 1'b0, "R10 busy", wr_ready, 0);
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      repeat (5) @(negedge clk);
      mdl[9000] = 1'b0; mdl[9001] = 1'b1;
      scan_check(9000, "R10 ack applied");
      scan_check(9001, "R10 write applied");

      // R4 disabled clear and ack
      reg_write(8'h00, 32'h0); en_m = 1'b0;
      op(1, 9001, "R4 clear disabled");
      op(2, 9001, "R4 ack disabled");
      reg_write(8'h00, 32'h1); en_m = 1'b1;

      // random traffic
      for (int n = 0; n < 300; n++) begin
         int kind = int'($urandom_range(0, 2));
         int id = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 20000))
                                                : 8192 + int'($urandom_range(0, 63));
         if ($urandom_range(0, 19) == 0) begin
            en_m = !en_m;
            reg_write(8'h00, {31'h0, en_m});
         end
         op(kind, id, kind == 0 ? "R2 rnd set" : (kind == 1 ? "R3 rnd clear" : "R7 rnd ack"));
         check(change_pulse == 1'b0, "R8 pulse ended", change_pulse, 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule